// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller collects up to 32 interrupt sources and presents one active-high interrupt request to a processor. Each source has its own settings:

- a mode register, holding a trigger type and a priority;
- a vector register, holding the word returned to the processor for that source.

A source is eligible when it is pending and its mask bit is set. Mask bits are never written directly. Software sets them through an enable command word and clears them through a disable command word. A separate read-only register shows the current mask, so software can save it and restore it.

The processor takes an interrupt by reading the vector register. The read returns the vector of the best eligible source: the highest priority wins, and on equal priority the lowest source number wins. The read also pushes that source's priority onto a hardware nesting stack with 8 levels. While that priority sits on top of the stack, only sources with a strictly higher priority can raise the request again. A write to the end-of-interrupt register pops one level. If nothing can win when the vector register is read, the read returns a programmable spurious vector and the stack is left alone.

Edge-triggered sources keep a latched pending bit. That bit is cleared by the vector read that selects the source, or by a pending-clear command. Level-triggered sources follow their input pin directly.

Top module: `intc_vec_ctrl`

## Requirements
- R1: A write to the enable-set command (address 0x41) sets each mask bit whose write-data bit is one. Mask bits whose write-data bit is zero keep their value.
- R2: A write to the disable command (address 0x42) clears each mask bit whose write-data bit is one, and zero bits have no effect. The current mask reads back at address 0x43.
- R3: The mode register of source i sits at address 0x00+i. Bits [2:0] hold the priority (7 is the highest). Bits [5:4] hold the trigger code: 0 is level high, 1 is rising edge, 2 is level low, 3 is falling edge. The written value reads back at the same address.
- R4: Only sources marked external in the parameter EXT_SRC_MASK (default: sources 29 to 31) keep trigger bit 5. On internal sources that bit is forced to zero, so code 2 acts as level high and reads back as 0.
- R5: The vector register of source i sits at address 0x20+i. A read of address 0x40 returns the vector of the eligible source with the highest priority, and the lowest source number on a tie.
- R6: If no eligible source has a priority strictly above the top of the stack, a read of 0x40 returns the spurious vector (address 0x46) and does not push the stack.
- R7: A vector read that selects a source pushes that source's priority onto the stack, which holds up to 8 levels. Each write to address 0x45 pops one level. A pop on an empty stack is ignored.
- R8: irq_o is high one cycle after an eligible source exists whose priority is strictly above the top of the stack. When the stack is empty, any priority counts.
- R9: An edge-triggered source becomes pending on an edge sampled at the clock, and stays pending until its vector is read. A level-triggered source is pending while its input is at the active level.
- R10: A write to address 0x44 clears the latched edge pending bit of every source whose write-data bit is one. Zero bits have no effect.
- R11: After reset every register is zero: the mask is empty, the stack is empty, irq_o is low, and a vector read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; qualifies the side effects of a vector read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| src_i | input | NUM_SRC | Interrupt source inputs |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A stack count that is wrong shows up at the ports within a few cycles, and it shows up in two ways:

- a vector read that should return a source's vector returns the spurious vector instead, or the reverse;
- irq_o stays low, or rises, one end-of-interrupt write earlier or later than expected.

For this reason the bench unwinds a full 8-level nest one pop at a time and watches irq_o at the step where the last level is popped. A latched edge bit that fails to clear shows up one vector read later, when the same vector is returned a second time. A wrong mask or trigger decode changes irq_o within two clock cycles of the stimulus.

// File: rtl/intc_vec_pkg.sv
package intc_vec_pkg;

   typedef enum logic [1:0] {
      TRIG_LVL_HI = 2'd0,
      TRIG_RISE   = 2'd1,
      TRIG_LVL_LO = 2'd2,
      TRIG_FALL   = 2'd3
   } trig_e;

   localparam int unsigned REG_MODE_BASE = 'h00;
   localparam int unsigned REG_VEC_BASE  = 'h20;
   localparam int unsigned REG_IVEC      = 'h40;
   localparam int unsigned REG_EN_SET    = 'h41;
   localparam int unsigned REG_EN_CLR    = 'h42;
   localparam int unsigned REG_MASK      = 'h43;
   localparam int unsigned REG_PEND_CLR  = 'h44;
   localparam int unsigned REG_EOI       = 'h45;
   localparam int unsigned REG_SPUR      = 'h46;

   localparam int unsigned MODE_TRIG_LSB = 4;

endpackage

// File: rtl/intc_src_detect.sv
module intc_src_detect #(
   parameter int unsigned NUM_SRC = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_SRC-1:0]      src_i,
   input  logic [NUM_SRC-1:0][1:0] trig_i,
   input  logic [NUM_SRC-1:0]      ack_i,
   input  logic [NUM_SRC-1:0]      clr_i,
   output logic [NUM_SRC-1:0]      pend_o
);

   if (NUM_SRC < 1) begin : g_bad_num
      $error("intc_src_detect: NUM_SRC must be at least 1");
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic prev_q;
      logic edge_q;
      logic edge_hit;
      logic lvl_act;

      // trig bit 1 selects the inverted sense, trig bit 0 selects edge mode
      assign lvl_act  = trig_i[i][1] ? ~src_i[i] : src_i[i];
      assign edge_hit = trig_i[i][1] ? (~src_i[i] & prev_q) : (src_i[i] & ~prev_q);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            edge_q <= 1'b0;
         end else begin
            prev_q <= src_i[i];
            if (!trig_i[i][0]) begin
               edge_q <= 1'b0;
            end else if (edge_hit) begin
               edge_q <= 1'b1;      // a fresh edge outranks a same-cycle clear
            end else if (ack_i[i] || clr_i[i]) begin
               edge_q <= 1'b0;
            end
         end
      end

      assign pend_o[i] = trig_i[i][0] ? edge_q : lvl_act;

      assert_edge_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_i[i] && !edge_hit) |=> !edge_q);

      assert_edge_clr_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !edge_hit) |=> !edge_q);
   end

endmodule

// File: rtl/intc_prio_select.sv
module intc_prio_select #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned PRIO_W  = 3,
   localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0]             cand_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   output logic                           valid_o,
   output logic [IDX_W-1:0]               idx_o,
   output logic [PRIO_W-1:0]              prio_o
);

   if (PRIO_W < 1) begin : g_bad_prio
      $error("intc_prio_select: PRIO_W must be at least 1");
   end

   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      prio_o  = '0;
      // strict compare keeps the lowest index among equal priorities
      for (int i = 0; i < NUM_SRC; i++) begin
         if (cand_i[i] && (!valid_o || (prio_i[i] > prio_o))) begin
            valid_o = 1'b1;
            idx_o   = IDX_W'(i);
            prio_o  = prio_i[i];
         end
      end
   end

endmodule

// File: rtl/intc_prio_stack.sv
module intc_prio_stack #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned PRIO_W = 3,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [PRIO_W-1:0] push_prio_i,
   input  logic              pop_i,
   output logic              empty_o,
   output logic              full_o,
   output logic [PRIO_W-1:0] top_o,
   output logic [CNT_W-1:0]  depth_o
);

   if (DEPTH < (1 << PRIO_W)) begin : g_bad_depth
      $error("intc_prio_stack: DEPTH must cover every priority level");
   end

   logic [PRIO_W-1:0] stk_q [DEPTH];
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int k = 0; k < DEPTH; k++) stk_q[k] <= '0;
      end else if (push_i && !full_o) begin
         stk_q[PTR_W'(cnt_q)] <= push_prio_i;
         cnt_q <= cnt_q + 1'b1;
      end else if (pop_i && !empty_o) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == CNT_W'(DEPTH));
   assign top_o   = empty_o ? '0 : stk_q[PTR_W'(cnt_q - 1'b1)];
   assign depth_o = cnt_q;

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);

   assert_push_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i) |=> (depth_o == $past(depth_o) + 1'b1));

   assert_pop_empty_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && empty_o) |=> empty_o);

endmodule

// File: rtl/intc_vec_ctrl.sv
module intc_vec_ctrl
   import intc_vec_pkg::*;
#(
   parameter int unsigned  NUM_SRC      = 32,
   parameter int unsigned  PRIO_W       = 3,
   parameter int unsigned  DATA_W       = 32,
   parameter int unsigned  ADDR_W       = 8,
   parameter int unsigned  STACK_DEPTH  = 8,
   parameter logic [31:0]  EXT_SRC_MASK = 32'hE000_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] src_i,
   output logic               irq_o
);

   localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int unsigned CNT_W = $clog2(STACK_DEPTH + 1);

   if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_num
      $error("intc_vec_ctrl: NUM_SRC must be 1..32");
   end
   if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_prio
      $error("intc_vec_ctrl: PRIO_W must be 1..4");
   end
   if (DATA_W < NUM_SRC || DATA_W < 6) begin : g_bad_data
      $error("intc_vec_ctrl: DATA_W too narrow");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("intc_vec_ctrl: ADDR_W too narrow for the register map");
   end

   // ---------------- register state ----------------
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
   logic [NUM_SRC-1:0][1:0]        trig_q;
   logic [DATA_W-1:0]              vec_q [NUM_SRC];
   logic [NUM_SRC-1:0]             mask_q;
   logic [DATA_W-1:0]              spur_q;
   logic                           irq_q;

   // ---------------- decode ----------------
   logic [NUM_SRC-1:0] wr_mode;
   logic [NUM_SRC-1:0] wr_vec;
   logic               vec_read;
   logic               wr_en_set;
   logic               wr_en_clr;
   logic               wr_pclr;
   logic               wr_eoi;
   logic               wr_spur;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
      assign wr_mode[i] = bus_wr && (bus_addr == ADDR_W'(REG_MODE_BASE + i));
      assign wr_vec[i]  = bus_wr && (bus_addr == ADDR_W'(REG_VEC_BASE + i));
   end

   assign vec_read  = bus_rd && (bus_addr == ADDR_W'(REG_IVEC));
   assign wr_en_set = bus_wr && (bus_addr == ADDR_W'(REG_EN_SET));
   assign wr_en_clr = bus_wr && (bus_addr == ADDR_W'(REG_EN_CLR));
   assign wr_pclr   = bus_wr && (bus_addr == ADDR_W'(REG_PEND_CLR));
   assign wr_eoi    = bus_wr && (bus_addr == ADDR_W'(REG_EOI));
   assign wr_spur   = bus_wr && (bus_addr == ADDR_W'(REG_SPUR));

   // ---------------- per-source configuration ----------------
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cfg
      localparam bit IS_EXT = EXT_SRC_MASK[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_q[i] <= '0;
            trig_q[i] <= '0;
            vec_q[i]  <= '0;
         end else begin
            if (wr_mode[i]) begin
               prio_q[i] <= bus_wdata[PRIO_W-1:0];
               trig_q[i] <= {bus_wdata[MODE_TRIG_LSB+1] & IS_EXT,
                             bus_wdata[MODE_TRIG_LSB]};
            end
            if (wr_vec[i]) vec_q[i] <= bus_wdata;
         end
      end

      assert_internal_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!IS_EXT && wr_mode[i]) |=> !trig_q[i][1]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         spur_q <= '0;
      end else begin
         if (wr_en_set) mask_q <= mask_q | bus_wdata[NUM_SRC-1:0];
         if (wr_en_clr) mask_q <= mask_q & ~bus_wdata[NUM_SRC-1:0];
         if (wr_spur)   spur_q <= bus_wdata;
      end
   end

   // ---------------- source detection ----------------
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] ack;
   logic [NUM_SRC-1:0] pclr;

   assign pclr = wr_pclr ? bus_wdata[NUM_SRC-1:0] : '0;

   intc_src_detect #(.NUM_SRC(NUM_SRC)) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i),
      .trig_i (trig_q),
      .ack_i  (ack),
      .clr_i  (pclr),
      .pend_o (pend)
   );

   // ---------------- arbitration ----------------
   logic [NUM_SRC-1:0] cand;
   logic               win_valid;
   logic [IDX_W-1:0]   win_idx;
   logic [PRIO_W-1:0]  win_prio;

   assign cand = pend & mask_q;

   intc_prio_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_select (
      .cand_i  (cand),
      .prio_i  (prio_q),
      .valid_o (win_valid),
      .idx_o   (win_idx),
      .prio_o  (win_prio)
   );

   // ---------------- nesting stack ----------------
   logic              stk_empty;
   logic              stk_full;
   logic [PRIO_W-1:0] stk_top;
   logic [CNT_W-1:0]  stk_depth;
   logic              beats;
   logic              take;

   assign beats = win_valid && (stk_empty || (win_prio > stk_top));
   assign take  = vec_read && beats;
   assign ack   = take ? (NUM_SRC'(1) << win_idx) : '0;

   intc_prio_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) u_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (take),
      .push_prio_i (win_prio),
      .pop_i       (wr_eoi),
      .empty_o     (stk_empty),
      .full_o      (stk_full),
      .top_o       (stk_top),
      .depth_o     (stk_depth)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= beats;
   end
   assign irq_o = irq_q;

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (bus_addr == ADDR_W'(REG_MODE_BASE + i)) begin
            bus_rdata[MODE_TRIG_LSB +: 2] = trig_q[i];
            bus_rdata[PRIO_W-1:0]         = prio_q[i];
         end
         if (bus_addr == ADDR_W'(REG_VEC_BASE + i)) bus_rdata = vec_q[i];
      end
      if (bus_addr == ADDR_W'(REG_IVEC)) bus_rdata = beats ? vec_q[win_idx] : spur_q;
      if (bus_addr == ADDR_W'(REG_MASK)) bus_rdata = DATA_W'(mask_q);
      if (bus_addr == ADDR_W'(REG_SPUR)) bus_rdata = spur_q;
   end

   // ---------------- assertions ----------------
   assert_mask_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_set && !wr_en_clr) |=>
         ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

   assert_mask_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_clr |=> ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

   assert_winner_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (pend[win_idx] && mask_q[win_idx]));

   assert_spur_no_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_read && !beats) |=> $stable(stk_depth));

   assert_irq_needs_cand_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(|cand));

   assert_stack_headroom_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !stk_full);

endmodule

// File: tb/intc_vec_ctrl_tb.sv
module intc_vec_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] src = '0;
   logic        irq_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   localparam logic [31:0] SPUR = 32'h0000_DEAD;

   always #2 clk = ~clk;

   intc_vec_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .src_i     (src),
      .irq_o     (irq_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic chk_irq(input string tag, input logic exp);
      settle();
      check(tag, {31'd0, irq_o}, {31'd0, exp});
   endtask

   task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(tag, d, exp);
   endtask

   task automatic t_reset();
      check("R11 irq after reset", {31'd0, irq_o}, 32'd0);
      chk_rd("R11 mask after reset", 8'h43, 32'd0);
      chk_rd("R11 mode after reset", 8'h05, 32'd0);
      chk_rd("R11 vector read after reset", 8'h40, 32'd0);
   endtask

   task automatic t_mask();
      wr(8'h41, 32'h0000_00F0);
      chk_rd("R1 set F0", 8'h43, 32'h0000_00F0);
      wr(8'h41, 32'h0000_0003);
      chk_rd("R1 set keeps others", 8'h43, 32'h0000_00F3);
      wr(8'h42, 32'h0000_0030);
      chk_rd("R2 clear 30", 8'h43, 32'h0000_00C3);
      wr(8'h42, 32'h0000_0000);
      chk_rd("R2 zero clear no effect", 8'h43, 32'h0000_00C3);
      wr(8'h42, 32'hFFFF_FFFF);
      chk_rd("R2 clear all", 8'h43, 32'h0);
   endtask

   task automatic t_mode();
      wr(8'h1F, 32'h25);
      chk_rd("R3 ext mode readback", 8'h1F, 32'h25);
      wr(8'h03, 32'h25);
      chk_rd("R4 internal low forced high", 8'h03, 32'h05);
      for (int i = 0; i < 32; i++) wr(8'(8'h20 + i), 32'h100 + i);
      chk_rd("R5 vector reg readback", 8'h2A, 32'h10A);
      wr(8'h46, SPUR);
      chk_rd("R6 spurious readback", 8'h46, SPUR);
   endtask

   task automatic t_level_prio();
      wr(8'h03, 32'h02);
      wr(8'h05, 32'h06);
      wr(8'h07, 32'h06);
      wr(8'h41, 32'h0000_00A8);
      src[3] = 1'b1; src[5] = 1'b1; src[7] = 1'b1;
      chk_irq("R8 irq with eligible", 1'b1);
      chk_rd("R5 tie lowest index", 8'h40, 32'h105);
      chk_irq("R8 equal prio blocked", 1'b0);
      chk_rd("R6 spurious when blocked", 8'h40, SPUR);
      wr(8'h45, 0);
      chk_irq("R6 spurious did not push", 1'b1);
      chk_rd("R9 level stays pending", 8'h40, 32'h105);
      wr(8'h45, 0);
      src[5] = 1'b0;
      chk_rd("R5 next same prio", 8'h40, 32'h107);
      wr(8'h45, 0);
      src[7] = 1'b0;
      chk_rd("R5 lower prio last", 8'h40, 32'h103);
      wr(8'h45, 0);
      src[3] = 1'b0;
      chk_irq("R9 level released", 1'b0);
      wr(8'h42, 32'hFFFF_FFFF);
   endtask

   task automatic t_nest();
      for (int k = 0; k < 8; k++) wr(8'(8 + k), k);
      wr(8'h41, 32'h0000_FF00);
      for (int k = 0; k < 8; k++) begin
         src[8 + k] = 1'b1;
         chk_rd("R7 nest push", 8'h40, 32'h108 + k);
      end
      chk_rd("R7 full nest spurious", 8'h40, SPUR);
      for (int k = 0; k < 7; k++) wr(8'h45, 0);
      src[15:9] = '0;
      chk_irq("R7 one level left blocks prio0", 1'b0);
      wr(8'h45, 0);
      chk_irq("R7 eighth pop unwinds", 1'b1);
      wr(8'h45, 0);
      chk_rd("R7 pop on empty ignored", 8'h40, 32'h108);
      wr(8'h45, 0);
      src[8] = 1'b0;
      chk_irq("R8 idle after unwind", 1'b0);
      wr(8'h42, 32'hFFFF_FFFF);
   endtask

   task automatic t_edge();
      wr(8'h1D, 32'h11);
      wr(8'h41, 32'h2000_0000);
      @(negedge clk) src[29] = 1'b1;
      @(negedge clk) src[29] = 1'b0;
      chk_irq("R9 rising latched", 1'b1);
      chk_rd("R9 rising vector", 8'h40, 32'h11D);
      wr(8'h45, 0);
      chk_irq("R9 ack cleared edge", 1'b0);
      chk_rd("R9 no second vector", 8'h40, SPUR);
      src[30] = 1'b1;
      settle();
      wr(8'h1E, 32'h34);
      wr(8'h41, 32'h4000_0000);
      chk_irq("R9 no falling yet", 1'b0);
      @(negedge clk) src[30] = 1'b0;
      chk_irq("R9 falling latched", 1'b1);
      chk_rd("R9 falling vector", 8'h40, 32'h11E);
      wr(8'h45, 0);
   endtask

   task automatic t_clear();
      @(negedge clk) src[29] = 1'b1;
      @(negedge clk) src[29] = 1'b0;
      chk_irq("R10 edge pending before clear", 1'b1);
      wr(8'h44, 32'h0);
      chk_irq("R10 zero clear no effect", 1'b1);
      wr(8'h44, 32'hFFFF_FFFF);
      chk_irq("R10 clear all drops irq", 1'b0);
      chk_rd("R10 cleared gives spurious", 8'h40, SPUR);
   endtask

   task automatic t_level_low();
      wr(8'h1F, 32'h21);
      wr(8'h41, 32'h8000_0000);
      chk_irq("R3 level low active", 1'b1);
      chk_rd("R3 level low vector", 8'h40, 32'h11F);
      wr(8'h45, 0);
      src[31] = 1'b1;
      chk_rd("R3 level low released", 8'h40, SPUR);
      wr(8'h42, 32'hFFFF_FFFF);
   endtask

   task automatic t_internal_type();
      wr(8'h03, 32'h25);
      wr(8'h41, 32'h0000_0008);
      chk_irq("R4 internal not level low", 1'b0);
      src[3] = 1'b1;
      chk_irq("R4 internal acts level high", 1'b1);
      chk_rd("R4 internal vector", 8'h40, 32'h103);
      wr(8'h45, 0);
      src[3] = 1'b0;
      wr(8'h42, 32'hFFFF_FFFF);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_mode();
      t_level_prio();
      t_nest();
      t_edge();
      t_clear();
      t_level_low();
      t_internal_type();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule